// File: doc/BRIEF.md
# Single-Source Interrupt Trigger Controller

This block watches one asynchronous interrupt pin and turns a programmable trigger condition on it into a sticky pending flag. Four trigger conditions are available: a low level, a high level, a falling edge or a rising edge. The pin first crosses into the clock domain through a chain of synchronizing flops. Edge detection compares the newest synchronized sample with the one before it.

Software reaches the block over a small word-wide read/write bus. The bus exposes a control word, a pending word and an enable word. The pending flag is cleared by writing a one. A registered interrupt output goes to the processor while the flag is pending and enabled. The address of the enable word is fixed at build time, so one design serves both address-map variants. The control and pending words are always at 0x00 and 0x04.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After a synchronous reset, with the pin held high, the control word, pending flag, enable bit and `irq_out` all read 0. The trigger mode is therefore low level.
- R2: In mode 0 (control bits [1:0] = 0, low level), the pending flag (bit 0 at offset 0x04) becomes set while the synchronized pin is low.
- R3: In mode 2 (high level), the pending flag becomes set while the synchronized pin is high, and a low pin does not set it.
- R4: In mode 1 (falling edge), only a high-to-low transition sets the flag. A pin held low after a clear does not set it again, and a rising transition does not set it.
- R5: In mode 3 (rising edge), only a low-to-high transition sets the flag. A pin held high after a clear does not set it again.
- R6: In either level mode, a clear while the pin is still at its active level is followed by the flag being set again one clock later.
- R7: A write to offset 0x04 with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged, whatever the other data bits hold.
- R8: `irq_out` is a register. It rises one clock after the enable bit (bit 0 of the enable word) and the pending flag are both 1. It stays low while the enable bit is 0, and the pending flag is still readable while masked.
- R9: All control word bits read back as written. Bits [1:0] are the mode and the upper bits are plain storage. The pending and enable words read 0 above bit 0.
- R10: The enable word sits at the byte offset given by `ENABLE_OFS` (0x08 by default, 0x34 in the other variant). The offset used by the other variant is unmapped.
- R11: If a trigger event and a clearing write occur in the same clock, the flag ends up set.
- R12: Reads of any offset other than the three mapped ones return 0. Writes to them change no state. Offsets are matched exactly, so unaligned addresses are unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous interrupt pin |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data, 0 when not selected |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench places a trigger event and a clearing write on the same clock edge. A design that let the clear win would lose that interrupt. It also holds the pin at the active level across a clear. In edge modes a design that confused edges with levels would set the flag again, and in level modes a correct design must set it again. The bench writes zero and stray upper bits to the pending word, which would wrongly clear a design that ignored bit position. It samples `irq_out` in the cycle after enabling, which catches a combinational or late output. A second instance built for the other map variant exposes any fixed enable address.

// File: rtl/irqtrig_pkg.sv
package irqtrig_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_RISE = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PEND,
        SEL_ENA
    } reg_sel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_view_t;

    localparam int unsigned CTRL_OFS = 32'h0000_0000;
    localparam int unsigned PEND_OFS = 32'h0000_0004;

    function automatic logic trig_hit(trig_mode_e mode, pin_view_t v);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = ~v.cur;
            TRIG_HIGH: hit = v.cur;
            TRIG_FALL: hit = v.prev & ~v.cur;
            TRIG_RISE: hit = ~v.prev & v.cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irqtrig_sync.sv
module irqtrig_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  d,
    output irqtrig_pkg::pin_view_t view
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= chain[STAGES-1];
    end

    assign view.cur  = chain[STAGES-1];
    assign view.prev = prev_q;
endmodule

// File: rtl/irqtrig_pend.sv
module irqtrig_pend
    import irqtrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  pin_view_t  view,
    input  logic       clr,
    output logic       pend_q
);
    logic hit;

    always_comb hit = trig_hit(mode, view);

    always_ff @(posedge clk) begin
        if (rst)      pend_q <= 1'b0;
        else if (hit) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q);

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !pend_q);

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hit) |=> $stable(pend_q));
endmodule

// File: rtl/irqtrig_regs.sv
module irqtrig_regs
    import irqtrig_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int ENABLE_OFS = 32'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend_q,
    output logic [DATA_W-1:0] rdata,
    output trig_mode_e        mode,
    output logic              ena,
    output logic              clr_pend
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENABLE_OFS);

    logic [DATA_W-1:0] ctrl_q;
    logic              ena_q;
    reg_sel_e          hit;

    always_comb begin
        if (addr == A_CTRL)      hit = SEL_CTRL;
        else if (addr == A_PEND) hit = SEL_PEND;
        else if (addr == A_ENA)  hit = SEL_ENA;
        else                     hit = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ena_q  <= 1'b0;
        end else if (sel && we) begin
            if (hit == SEL_CTRL) ctrl_q <= wdata;
            if (hit == SEL_ENA)  ena_q  <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (hit)
                SEL_CTRL: rdata    = ctrl_q;
                SEL_PEND: rdata[0] = pend_q;
                SEL_ENA:  rdata[0] = ena_q;
                default:  rdata    = '0;
            endcase
        end
    end

    assign clr_pend = sel && we && (hit == SEL_PEND) && wdata[0];
    assign mode     = trig_mode_e'(ctrl_q[1:0]);
    assign ena      = ena_q;

    // R12
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && we && hit == SEL_NONE) |=> ($stable(ctrl_q) && $stable(ena_q)));
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
    import irqtrig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ENABLE_OFS  = 32'h08,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    pin_view_t  view;
    trig_mode_e mode;
    logic       ena;
    logic       clr_pend;
    logic       pend_q;

    irqtrig_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (pin_in),
        .view (view)
    );

    irqtrig_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ENABLE_OFS (ENABLE_OFS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pend_q   (pend_q),
        .rdata    (bus_rdata),
        .mode     (mode),
        .ena      (ena),
        .clr_pend (clr_pend)
    );

    irqtrig_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .view   (view),
        .clr    (clr_pend),
        .pend_q (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= pend_q & ena;
    end

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !ena |=> !irq_out);

    // R8
    no_pend_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> !irq_out);
endmodule

// File: tb/test_irq_trigger_ctrl.sv
`timescale 1ns/1ps
module test_irq_trigger_ctrl;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_PEND = 8'h04;
    localparam logic [7:0] A_ENA  = 8'h08;
    localparam logic [7:0] A_ALT  = 8'h34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b1;
    logic        sel = 1'b0;
    logic        we  = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic        irq, irq_alt;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_trigger_ctrl i_irq_trigger_ctrl (
        .clk(clk), .rst(rst), .pin_in(pin), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

    irq_trigger_ctrl #(.ENABLE_OFS(32'h34)) i_irq_trigger_ctrl_alt (
        .clk(clk), .rst(rst), .pin_in(pin), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_alt), .irq_out(irq_alt));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d, output logic [31:0] d_alt);
        sel = 1'b1; we = 1'b0; addr = a;
        #1;
        d = rdata; d_alt = rdata_alt;
        sel = 1'b0;
    endtask

    task automatic read_main(logic [7:0] a, output logic [31:0] d);
        logic [31:0] dummy;
        bus_read(a, d, dummy);
    endtask

    task automatic prep(logic [1:0] mode, logic idle_level);
        pin = idle_level;
        bus_write(A_CTRL, {30'd0, mode});
        wait_cyc(5);
        bus_write(A_PEND, 32'h1);
        wait_cyc(1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read_main(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        read_main(A_PEND, v); check("R1 pend", v, 32'h0);
        read_main(A_ENA, v);  check("R1 ena", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_low_level;
        logic [31:0] v;
        prep(2'd0, 1'b1);
        read_main(A_PEND, v); check("R2 idle high no pend", v, 32'h0);
        pin = 1'b0; wait_cyc(5);
        read_main(A_PEND, v); check("R2 low sets pend", v, 32'h1);
        bus_write(A_PEND, 32'h1);
        wait_cyc(1);
        read_main(A_PEND, v); check("R6 low still active re-sets", v, 32'h1);
        pin = 1'b1; wait_cyc(4);
        bus_write(A_PEND, 32'h1); wait_cyc(2);
        read_main(A_PEND, v); check("R2 cleared after release", v, 32'h0);
    endtask

    task automatic t_high_level;
        logic [31:0] v;
        prep(2'd2, 1'b0);
        wait_cyc(4);
        read_main(A_PEND, v); check("R3 low does not set", v, 32'h0);
        pin = 1'b1; wait_cyc(5);
        read_main(A_PEND, v); check("R3 high sets pend", v, 32'h1);
        bus_write(A_PEND, 32'h1); wait_cyc(1);
        read_main(A_PEND, v); check("R6 high still active re-sets", v, 32'h1);
        pin = 1'b0; wait_cyc(4);
        bus_write(A_PEND, 32'h1); wait_cyc(3);
        read_main(A_PEND, v); check("R3 clear holds when low", v, 32'h0);
    endtask

    task automatic t_falling;
        logic [31:0] v;
        prep(2'd1, 1'b1);
        pin = 1'b0; wait_cyc(5);
        read_main(A_PEND, v); check("R4 fall sets pend", v, 32'h1);
        bus_write(A_PEND, 32'h1); wait_cyc(5);
        read_main(A_PEND, v); check("R4 held low no re-set", v, 32'h0);
        pin = 1'b1; wait_cyc(5);
        read_main(A_PEND, v); check("R4 rise ignored", v, 32'h0);
    endtask

    task automatic t_rising;
        logic [31:0] v;
        prep(2'd3, 1'b0);
        pin = 1'b1; wait_cyc(5);
        read_main(A_PEND, v); check("R5 rise sets pend", v, 32'h1);
        bus_write(A_PEND, 32'h1); wait_cyc(5);
        read_main(A_PEND, v); check("R5 held high no re-set", v, 32'h0);
        pin = 1'b0; wait_cyc(5);
        read_main(A_PEND, v); check("R5 fall ignored", v, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        prep(2'd3, 1'b0);
        pin = 1'b1; wait_cyc(5);
        bus_write(A_PEND, 32'h0); wait_cyc(1);
        read_main(A_PEND, v); check("R7 write 0 keeps", v, 32'h1);
        bus_write(A_PEND, 32'hFFFF_FFFE); wait_cyc(1);
        read_main(A_PEND, v); check("R7 upper bits keep", v, 32'h1);
        bus_write(A_PEND, 32'h1); wait_cyc(1);
        read_main(A_PEND, v); check("R7 write 1 clears", v, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        prep(2'd3, 1'b0);
        pin = 1'b1; wait_cyc(5);
        wait_cyc(3);
        check("R8 masked irq low", {31'd0, irq}, 32'h0);
        read_main(A_PEND, v); check("R8 pend visible masked", v, 32'h1);
        bus_write(A_ENA, 32'h1);
        check("R8 irq not yet (registered)", {31'd0, irq}, 32'h0);
        wait_cyc(1);
        check("R8 irq one clock after enable", {31'd0, irq}, 32'h1);
        bus_write(A_ENA, 32'h0); wait_cyc(1);
        check("R8 irq drops when masked", {31'd0, irq}, 32'h0);
        bus_write(A_ENA, 32'h1); wait_cyc(1);
        bus_write(A_PEND, 32'h1); wait_cyc(1);
        check("R8 irq drops after clear", {31'd0, irq}, 32'h0);
        bus_write(A_ENA, 32'h0);
    endtask

    task automatic t_storage;
        logic [31:0] v;
        pin = 1'b0;
        bus_write(A_CTRL, 32'hA5A5_5A03);
        read_main(A_CTRL, v); check("R9 ctrl readback", v, 32'hA5A5_5A03);
        bus_write(A_CTRL, (v & ~32'h3) | 32'h1);
        read_main(A_CTRL, v); check("R9 upper kept after mode change", v, 32'hA5A5_5A01);
        bus_write(A_ENA, 32'hFFFF_FFFF);
        read_main(A_ENA, v); check("R9 ena upper zero", v, 32'h1);
        bus_write(A_ENA, 32'h0);
        pin = 1'b1; wait_cyc(3);
        pin = 1'b0; wait_cyc(5);
        read_main(A_PEND, v); check("R9 pend upper zero", v, 32'h1);
    endtask

    task automatic t_offset;
        logic [31:0] v, va;
        prep(2'd3, 1'b0);
        pin = 1'b1; wait_cyc(5);
        bus_write(A_ALT, 32'h1); wait_cyc(2);
        bus_read(A_ALT, v, va);
        check("R10 main alt offset unmapped", v, 32'h0);
        check("R10 alt enable at 0x34", va, 32'h1);
        check("R10 main irq stays masked", {31'd0, irq}, 32'h0);
        check("R10 alt irq raised", {31'd0, irq_alt}, 32'h1);
        bus_write(A_ENA, 32'h1); wait_cyc(2);
        bus_read(A_ENA, v, va);
        check("R10 main enable at 0x08", v, 32'h1);
        check("R10 alt 0x08 unmapped", va, 32'h0);
        check("R10 main irq raised", {31'd0, irq}, 32'h1);
        bus_write(A_ENA, 32'h0);
        bus_write(A_ALT, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h0000_1203);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        read_main(A_CTRL, v); check("R12 ctrl untouched", v, 32'h0000_1203);
        read_main(A_ENA, v);  check("R12 ena untouched", v, 32'h0);
        read_main(8'h0C, v);  check("R12 read 0x0C zero", v, 32'h0);
        read_main(8'h05, v);  check("R12 unaligned read zero", v, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        prep(2'd3, 1'b0);
        pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(A_PEND, 32'h1);
        read_main(A_PEND, v); check("R11 event wins over clear", v, 32'h1);
        bus_write(A_PEND, 32'h1); wait_cyc(1);
        read_main(A_PEND, v); check("R11 later clear works", v, 32'h0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_low_level();
        t_high_level();
        t_falling();
        t_rising();
        t_w1c();
        t_enable();
        t_storage();
        t_offset();
        t_unmapped();
        t_race();
        report();
    end
endmodule